// File: doc/BRIEF.md
# Privilege-Level Interrupt Router

This block sits between a processor's interrupt inputs and its exception-entry logic. It receives three classes of asynchronous interrupt: ordinary interrupts, fast interrupts and system errors. It decides, every cycle, whether one of them should be taken now and at which of four privilege levels (0 to 3) the handler will run. Two routing registers steer each class. The top-level (monitor) register sends a class to level 3, and when it claims a class it overrides the level-2 (hypervisor) register. When neither register claims a class, the class stays at level 1, or at the current level if that level is higher.

A routed interrupt is held pending while the processor runs above its target level. Interrupts are never dropped. A masked or out-of-reach class simply waits until it becomes takeable. Software running at level 2 can set a virtual pending bit per class. A virtual interrupt always targets level 1, and taking it clears its pending bit.

The output is a one-cycle take strobe together with the chosen class, the target level and a virtual flag. The strobe is gated by a global enable that the exception-entry logic drops when it accepts the interrupt. The block does not save state or fetch vectors.

Top module: `irq_route_top`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it, `takeExc`, `takeVirtual`, `takeClass`, `takeLevel` and `virtPending` are all zero.
- R2: Class codes are IRQ=0, FIQ=1, SERR=2, and bit c of every per-class vector belongs to class c. A class whose `monRoute` bit is set is taken with `takeLevel`=3 when level 3 is implemented.
- R3: When both `monRoute` and `hypRoute` are set for a class, the monitor setting wins and the target is 3.
- R4: A class with only its `hypRoute` bit set targets level 2 when level 2 is implemented.
- R5: A class claimed by neither register targets level 1, or `curLevel` when `curLevel` is greater than 1. Level 0 is never a target.
- R6: A physical interrupt is not taken while `curLevel` is above its target. It stays pending and is taken once `curLevel` is at or below the target.
- R7: A class whose `maskBits` bit is set is not taken. It is taken once the mask clears, provided its line is still asserted.
- R8: When several classes are takeable in the same cycle, the winner is SERR, then FIQ, then IRQ, and any physical class beats any virtual one.
- R9: A `virtSet` bit sets the matching `virtPending` bit only while `curLevel`=2 and is ignored at other levels. A virtual interrupt targets level 1 and is taken only when `curLevel` is at most 1 and its class is unmasked. Taking it clears its pending bit.
- R10: `takeExc` is high for exactly one cycle per take. A take needs `globalEn` high, and no take is made in the cycle directly after a take.
- R11: With `HAS_L3`=0 the `monRoute` bits are ignored. With `HAS_L2`=0 the `hypRoute` bits are ignored.
- R12: The outputs are registered. A decision made from the inputs during cycle t appears on the outputs after the clock edge that ends cycle t.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLine | input | 3 | Raw physical interrupt lines, one per class |
| curLevel | input | 2 | Current privilege level |
| maskBits | input | 3 | Per-class mask; 1 blocks the class |
| monRoute | input | 3 | Monitor routing bits; 1 sends the class to level 3 |
| hypRoute | input | 3 | Hypervisor routing bits; 1 sends the class to level 2 |
| virtSet | input | 3 | Software request to set a virtual pending bit |
| globalEn | input | 1 | Global interrupt enable from the entry logic |
| takeExc | output | 1 | One-cycle take strobe |
| takeVirtual | output | 1 | The take is a virtual interrupt |
| takeClass | output | 2 | Class that is taken (0 IRQ, 1 FIQ, 2 SERR) |
| takeLevel | output | 2 | Level that the interrupt is taken to |
| virtPending | output | 3 | Virtual pending bits |

## Verification
The bench builds two copies of the block side by side and drives both with the same stimulus. One copy uses the defaults, with both optional levels present, so that monitor override, hypervisor routing and pending-until-drop can be reached. The other copy has `HAS_L2`=0 and `HAS_L3`=0, so that every routing bit must be ignored and every physical target falls back to level 1 or the current level. Directed steps cover each requirement's corner. A long random run then mixes the levels, the masks, the enable and simultaneous classes, so that priority and the pulse holdoff meet each other.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int NUM_CLS = 3;
  localparam int LVL_W   = 2;
  localparam int CLS_W   = $clog2(NUM_CLS);

  typedef enum logic [CLS_W-1:0] {
    CLS_IRQ  = 2'd0,
    CLS_FIQ  = 2'd1,
    CLS_SERR = 2'd2
  } intClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic               take;
    logic               isVirt;
    logic [CLS_W-1:0]   cls;
    logic [NUM_CLS-1:0] virtAck;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter bit HAS_L2 = 1'b1,
  parameter bit HAS_L3 = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CLS-1:0] irqLine,
  input  logic [LVL_W-1:0]   curLevel,
  input  logic [NUM_CLS-1:0] maskBits,
  input  logic [NUM_CLS-1:0] monRoute,
  input  logic [NUM_CLS-1:0] hypRoute,
  input  logic [NUM_CLS-1:0] virtSet,
  input  ctrlStrobe_t        strobe,
  output logic [NUM_CLS-1:0] physReady,
  output logic [NUM_CLS-1:0] virtReady,
  output logic               takeExc,
  output logic               takeVirtual,
  output logic [CLS_W-1:0]   takeClass,
  output logic [LVL_W-1:0]   takeLevel,
  output logic [NUM_CLS-1:0] virtPending
);
  localparam logic [LVL_W-1:0] LVL_ONE = LVL_W'(1);
  localparam logic [LVL_W-1:0] LVL_HYP = LVL_W'(2);
  localparam logic [LVL_W-1:0] LVL_MON = LVL_W'(3);

  logic [NUM_CLS-1:0][LVL_W-1:0] physTgt;
  logic [LVL_W-1:0] defaultTgt;
  logic [LVL_W-1:0] selLevel;
  logic             virtWriteOk;

  assign defaultTgt  = (curLevel > LVL_ONE) ? curLevel : LVL_ONE;
  assign virtWriteOk = (curLevel == LVL_HYP);

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    logic monHit, hypHit;
    assign monHit = HAS_L3 && monRoute[c];
    assign hypHit = HAS_L2 && hypRoute[c];
    // monitor claim overrides hypervisor claim
    assign physTgt[c]   = monHit ? LVL_MON : (hypHit ? LVL_HYP : defaultTgt);
    assign physReady[c] = irqLine[c] && !maskBits[c] && (curLevel <= physTgt[c]);
    assign virtReady[c] = virtPending[c] && !maskBits[c] && (curLevel <= LVL_ONE);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        virtPending[c] <= 1'b0;
      end else if (virtWriteOk && virtSet[c]) begin
        virtPending[c] <= 1'b1;
      end else if (strobe.virtAck[c]) begin
        virtPending[c] <= 1'b0;
      end
    end
  end

  always_comb begin
    selLevel = LVL_ONE;
    if (!strobe.isVirt) begin
      for (int c = 0; c < NUM_CLS; c++) begin
        if (strobe.cls == CLS_W'(c)) selLevel = physTgt[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takeExc     <= 1'b0;
      takeVirtual <= 1'b0;
      takeClass   <= '0;
      takeLevel   <= '0;
    end else begin
      takeExc     <= strobe.take;
      takeVirtual <= strobe.take && strobe.isVirt;
      takeClass   <= strobe.take ? strobe.cls : '0;
      takeLevel   <= strobe.take ? selLevel : '0;
    end
  end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
(
  input  logic [NUM_CLS-1:0] physReady,
  input  logic [NUM_CLS-1:0] virtReady,
  input  logic               globalEn,
  input  logic               holdOff,
  output ctrlStrobe_t        strobe
);
  logic             physAny, virtAny;
  logic [CLS_W-1:0] physSel, virtSel;

  // ascending scan: the highest class number wins
  always_comb begin
    physAny = 1'b0;
    virtAny = 1'b0;
    physSel = '0;
    virtSel = '0;
    for (int c = 0; c < NUM_CLS; c++) begin
      if (physReady[c]) begin
        physAny = 1'b1;
        physSel = CLS_W'(c);
      end
      if (virtReady[c]) begin
        virtAny = 1'b1;
        virtSel = CLS_W'(c);
      end
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.take    = globalEn && !holdOff && (physAny || virtAny);
    strobe.isVirt  = !physAny;
    strobe.cls     = physAny ? physSel : virtSel;
    if (strobe.take && !physAny) begin
      for (int c = 0; c < NUM_CLS; c++) begin
        strobe.virtAck[c] = (virtSel == CLS_W'(c));
      end
    end
  end
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter bit HAS_L2 = 1'b1,
  parameter bit HAS_L3 = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [2:0]   irqLine,
  input  logic [1:0]   curLevel,
  input  logic [2:0]   maskBits,
  input  logic [2:0]   monRoute,
  input  logic [2:0]   hypRoute,
  input  logic [2:0]   virtSet,
  input  logic         globalEn,
  output logic         takeExc,
  output logic         takeVirtual,
  output logic [1:0]   takeClass,
  output logic [1:0]   takeLevel,
  output logic [2:0]   virtPending
);
  ctrlStrobe_t        strobe;
  logic [NUM_CLS-1:0] physReady, virtReady;

  irq_route_ctrl u_ctrl (
    .physReady (physReady),
    .virtReady (virtReady),
    .globalEn  (globalEn),
    .holdOff   (takeExc),
    .strobe    (strobe)
  );

  irq_route_dp #(.HAS_L2(HAS_L2), .HAS_L3(HAS_L3)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .irqLine     (irqLine),
    .curLevel    (curLevel),
    .maskBits    (maskBits),
    .monRoute    (monRoute),
    .hypRoute    (hypRoute),
    .virtSet     (virtSet),
    .strobe      (strobe),
    .physReady   (physReady),
    .virtReady   (virtReady),
    .takeExc     (takeExc),
    .takeVirtual (takeVirtual),
    .takeClass   (takeClass),
    .takeLevel   (takeLevel),
    .virtPending (virtPending)
  );
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] irqLine,
  input logic [1:0] curLevel,
  input logic [2:0] maskBits,
  input logic [2:0] virtSet,
  input logic       globalEn,
  input logic       takeExc,
  input logic       takeVirtual,
  input logic [1:0] takeClass,
  input logic [1:0] takeLevel,
  input logic [2:0] virtPending
);
  logic [3:0] maskQ;
  logic [3:0] lineQ;
  always_ff @(posedge clk) begin
    maskQ <= {1'b0, maskBits};
    lineQ <= {1'b0, irqLine};
  end

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |=> !takeExc);
  a_r10_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |-> $past(globalEn));
  a_r5_level_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |-> takeLevel != 2'd0);
  a_r8_class_legal: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |-> takeClass != 2'd3);
  a_r6_not_below_current: assert property (@(posedge clk) disable iff (!rstN)
    (takeExc && !takeVirtual) |-> $past(curLevel) <= takeLevel);
  a_r7_masked_not_taken: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |-> !maskQ[takeClass]);
  a_r7_line_present: assert property (@(posedge clk) disable iff (!rstN)
    (takeExc && !takeVirtual) |-> lineQ[takeClass]);
  a_r9_virt_level_one: assert property (@(posedge clk) disable iff (!rstN)
    (takeExc && takeVirtual) |-> (takeLevel == 2'd1 && $past(curLevel) <= 2'd1));
  a_r9_virt_set_at_two: assert property (@(posedge clk) disable iff (!rstN)
    ((virtPending & ~$past(virtPending)) != 3'b0) |-> ($past(curLevel) == 2'd2 && $past(virtSet) != 3'b0));
endmodule

bind irq_route_top irq_route_chk u_chk (.*);

// File: tb/irq_route_top_bench.sv
module irq_route_top_bench;
  typedef struct packed {
    logic       take;
    logic       virt;
    logic [1:0] cls;
    logic [1:0] lvl;
    logic [2:0] vp;
  } exp_t;

  logic clk = 1'b0;
  logic rstN;
  logic [2:0] irqLine, maskBits, monRoute, hypRoute, virtSet;
  logic [1:0] curLevel;
  logic globalEn;

  logic       tA, vA, tB, vB;
  logic [1:0] cA, lA, cB, lB;
  logic [2:0] pA, pB;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  exp_t expA, expB;
  logic [2:0] vpA, vpB;
  logic heldA, heldB;

  always #5 clk = ~clk;

  irq_route_top u_irq_route_top (
    .clk(clk), .rstN(rstN), .irqLine(irqLine), .curLevel(curLevel),
    .maskBits(maskBits), .monRoute(monRoute), .hypRoute(hypRoute),
    .virtSet(virtSet), .globalEn(globalEn), .takeExc(tA), .takeVirtual(vA),
    .takeClass(cA), .takeLevel(lA), .virtPending(pA));

  irq_route_top #(.HAS_L2(1'b0), .HAS_L3(1'b0)) u_irq_route_top_min (
    .clk(clk), .rstN(rstN), .irqLine(irqLine), .curLevel(curLevel),
    .maskBits(maskBits), .monRoute(monRoute), .hypRoute(hypRoute),
    .virtSet(virtSet), .globalEn(globalEn), .takeExc(tB), .takeVirtual(vB),
    .takeClass(cB), .takeLevel(lB), .virtPending(pB));

  function automatic exp_t model(input logic [2:0] vp, input logic held, input bit h2, input bit h3);
    exp_t e;
    logic [1:0] tgt;
    e = '0;
    for (int c = 2; c >= 0; c--) begin
      if (h3 && monRoute[c]) tgt = 2'd3;
      else if (h2 && hypRoute[c]) tgt = 2'd2;
      else tgt = (curLevel > 2'd1) ? curLevel : 2'd1;
      if (!e.take && globalEn && !held && irqLine[c] && !maskBits[c] && curLevel <= tgt) begin
        e.take = 1'b1; e.cls = 2'(c); e.lvl = tgt;
      end
    end
    e.vp = vp;
    for (int c = 2; c >= 0; c--) begin
      if (!e.take && globalEn && !held && vp[c] && !maskBits[c] && curLevel <= 2'd1) begin
        e.take = 1'b1; e.virt = 1'b1; e.cls = 2'(c); e.lvl = 2'd1;
        e.vp[c] = 1'b0;
      end
    end
    if (curLevel == 2'd2) e.vp = e.vp | virtSet;
    return e;
  endfunction

  task automatic compare(input string tag, input exp_t got, input exp_t exp, input string inst);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got take=%b virt=%b cls=%0d lvl=%0d vp=%b expected take=%b virt=%b cls=%0d lvl=%0d vp=%b",
               tag, inst, got.take, got.virt, got.cls, got.lvl, got.vp,
               exp.take, exp.virt, exp.cls, exp.lvl, exp.vp);
    end
  endtask

  // inputs are already applied at a falling edge; one rising edge, then check
  task automatic step(input string tag);
    expA = model(vpA, heldA, 1'b1, 1'b1);
    expB = model(vpB, heldB, 1'b0, 1'b0);
    @(negedge clk);
    compare(tag, {tA, vA, cA, lA, pA}, expA, "full");
    compare(tag, {tB, vB, cB, lB, pB}, expB, "min");
    vpA = expA.vp; heldA = expA.take;
    vpB = expB.vp; heldB = expB.take;
  endtask

  task automatic drive(input logic [2:0] line, input logic [1:0] cur, input logic [2:0] msk,
                       input logic [2:0] mon, input logic [2:0] hyp, input logic [2:0] vs,
                       input logic en);
    irqLine = line; curLevel = cur; maskBits = msk;
    monRoute = mon; hypRoute = hyp; virtSet = vs; globalEn = en;
  endtask

  task automatic idle();
    drive(3'b0, 2'd0, 3'b0, 3'b0, 3'b0, 3'b0, 1'b1);
    step("idle");
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    drive(3'b111, 2'd0, 3'b0, 3'b0, 3'b0, 3'b111, 1'b1);
    vpA = '0; vpB = '0; heldA = 0; heldB = 0;
    repeat (3) @(negedge clk);
    // R1: reset holds everything at zero
    compare("R1 reset", {tA, vA, cA, lA, pA}, '0, "full");
    compare("R1 reset", {tB, vB, cB, lB, pB}, '0, "min");
    drive(3'b0, 2'd0, 3'b0, 3'b0, 3'b0, 3'b0, 1'b1);
    rstN = 1'b1;
    @(negedge clk);
    compare("R1 after reset", {tA, vA, cA, lA, pA}, '0, "full");

    // R2 / R12: monitor routing of IRQ to level 3
    idle();
    drive(3'b001, 2'd0, 3'b0, 3'b001, 3'b0, 3'b0, 1'b1); step("R2 R12 monitor route");
    // R3 / R11: both claims on FIQ, monitor wins; min build ignores both
    idle();
    drive(3'b010, 2'd0, 3'b0, 3'b010, 3'b010, 3'b0, 1'b1); step("R3 R11 override");
    // R4: hypervisor only
    idle();
    drive(3'b001, 2'd1, 3'b0, 3'b0, 3'b001, 3'b0, 1'b1); step("R4 hyp route");
    // R5: default target at level 3 and at level 0
    idle();
    drive(3'b100, 2'd3, 3'b0, 3'b0, 3'b0, 3'b0, 1'b1); step("R5 default current");
    idle();
    drive(3'b100, 2'd0, 3'b0, 3'b0, 3'b0, 3'b0, 1'b1); step("R5 default one");
    // R6: pending while above target, taken after drop
    idle();
    drive(3'b001, 2'd3, 3'b0, 3'b0, 3'b001, 3'b0, 1'b1); step("R6 pending above");
    drive(3'b001, 2'd3, 3'b0, 3'b0, 3'b001, 3'b0, 1'b1); step("R6 still pending");
    drive(3'b001, 2'd2, 3'b0, 3'b0, 3'b001, 3'b0, 1'b1); step("R6 taken after drop");
    // R7: masked then unmasked
    idle();
    drive(3'b010, 2'd0, 3'b010, 3'b0, 3'b0, 3'b0, 1'b1); step("R7 masked");
    drive(3'b010, 2'd0, 3'b000, 3'b0, 3'b0, 3'b0, 1'b1); step("R7 unmasked");
    // R8: priority
    idle();
    drive(3'b111, 2'd0, 3'b0, 3'b0, 3'b0, 3'b0, 1'b1); step("R8 serr first");
    idle();
    drive(3'b011, 2'd0, 3'b0, 3'b0, 3'b0, 3'b0, 1'b1); step("R8 fiq over irq");
    // R9: virtual set ignored off level 2, set at level 2, taken at level 0
    idle();
    drive(3'b0, 2'd1, 3'b0, 3'b0, 3'b0, 3'b111, 1'b1); step("R9 set ignored");
    drive(3'b0, 2'd2, 3'b0, 3'b0, 3'b0, 3'b011, 1'b1); step("R9 set at two");
    drive(3'b0, 2'd2, 3'b0, 3'b0, 3'b0, 3'b000, 1'b1); step("R9 not taken at two");
    drive(3'b001, 2'd0, 3'b0, 3'b0, 3'b0, 3'b000, 1'b1); step("R8 R9 physical beats virtual");
    drive(3'b000, 2'd0, 3'b0, 3'b0, 3'b0, 3'b000, 1'b1); step("R10 holdoff");
    drive(3'b000, 2'd0, 3'b0, 3'b0, 3'b0, 3'b000, 1'b1); step("R9 virtual taken");
    // R10: enable gating and single pulse
    idle();
    drive(3'b100, 2'd0, 3'b0, 3'b0, 3'b0, 3'b0, 1'b0); step("R10 disabled");
    drive(3'b100, 2'd0, 3'b0, 3'b0, 3'b0, 3'b0, 1'b1); step("R10 enabled");
    drive(3'b100, 2'd0, 3'b0, 3'b0, 3'b0, 3'b0, 1'b1); step("R10 one pulse");

    // random mix
    void'($urandom(32'd4242));
    for (int i = 0; i < 2000; i++) begin
      drive(3'($urandom), 2'($urandom), 3'($urandom & $urandom), 3'($urandom),
            3'($urandom), 3'($urandom & $urandom), ($urandom % 4) != 0);
      step("R2 R8 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule